// File: doc/BRIEF.md
# MCU Sleep Mode Controller

This block decides when a small microcontroller core may stop and which clocks stop with it. Software writes an 8-bit control register that holds a sleep-enable flag, a two-bit mode field, a pull-up kill bit and two interrupt-sense bits. When the core executes its sleep instruction while the enable flag is set, the controller halts the core. It then drops the run enables of the clock domains that the chosen mode stops: CPU clock, I/O clock, ADC clock and main oscillator.

An enabled interrupt or a system reset ends the sleep. The controller first lets the oscillator settle for a start-up time that depends on the mode. It then runs every clock while still holding the core for four further cycles. Finally it releases the core with a one-cycle pulse that tells the core which exit to take: service the interrupt, or restart from the reset vector. The same register bit that ends pull-ups is applied here to a vector of pin direction and output bits, so that the port logic receives a ready pull-up enable for each pin.

Top module: `slp_ctrl`

## Requirements
- R1: The control register resets to 0x00. Bits 7 and 2 always read as 0. Bit 6 is pull-up disable, bit 5 is sleep enable, bits 4:3 are the mode and bits 1:0 drive `int_sense`. A write stores the data with bits 7 and 2 forced to 0.
- R2: `sleep_exec` while running with bit 5 set raises `core_halt` on the next cycle. With bit 5 clear, `sleep_exec` leaves `core_halt` low and every clock running.
- R3: While asleep, the run outputs {cpu,io,adc,osc} are as follows for each mode: 00 Idle = 0111, 01 ADC-quiet = 0011, 10 Power-down = 0000, 11 Standby = 0001. While running, all four are 1.
- R4: The mode is captured when sleep starts. Register writes made during sleep do not change the gating or the wake timing.
- R5: After `irq_wake` is sampled during sleep, `core_halt` stays high for D+4 more cycles. D is 0 for Idle and ADC-quiet, 6 for Standby and 40 for Power-down. `resume_irq` is then high in the first cycle with `core_halt` low.
- R6: During the D start-up cycles the clock run outputs follow the mode with the oscillator forced on. During the following four hold cycles all four run outputs are 1.
- R7: `sys_rst_req` during sleep wakes the core with the same timing as R5, but pulses `resume_reset` instead of `resume_irq`. It wins over a simultaneous `irq_wake` and clears the register to 0x00.
- R8: `sys_rst_req` while running clears the register, leaves `core_halt` low and raises no resume pulse.
- R9: `pullup_en[i]` is 1 only when `pin_dir[i]` is 0, `pin_out[i]` is 1 and register bit 6 is 0.
- R10: `irq_wake` while running is ignored. `sleep_exec` while the core is halted does not change the wake timing or the exit kind.
- R11: The two resume pulses are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sys_rst_req | input | 1 | System reset event; wakes the core and clears the register |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| sleep_exec | input | 1 | Core is executing its sleep instruction |
| irq_wake | input | 1 | An enabled interrupt is pending |
| pin_dir | input | NPINS | Pin direction bits (1 = output) |
| pin_out | input | NPINS | Pin output/data bits |
| pullup_en | output | NPINS | Per-pin pull-up enable |
| int_sense | output | 2 | Interrupt sense selection from bits 1:0 |
| core_halt | output | 1 | Core must not execute |
| cpu_clk_run | output | 1 | CPU clock domain runs |
| io_clk_run | output | 1 | I/O clock domain runs |
| adc_clk_run | output | 1 | ADC clock domain runs |
| osc_run | output | 1 | Main oscillator enabled |
| resume_irq | output | 1 | One-cycle pulse: take the pending interrupt |
| resume_reset | output | 1 | One-cycle pulse: restart at the reset vector |

## Verification
A wrong sequencer state or a stale latched mode shows at the clock run outputs in the same cycle. A miscounted start-up or hold counter shows as a halt window that ends too early or too late, and as a resume pulse in the wrong cycle. The bench counts that window cycle by cycle against D+4. A lost reset path shows at the exit, where `resume_irq` fires instead of `resume_reset`, and as a register that is not read back as zero.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_ADCQ  = 2'b01,
    MODE_PDOWN = 2'b10,
    MODE_STBY  = 2'b11
  } slp_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_START,
    ST_HOLD
  } seq_st_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic osc;
  } gate_t;

  localparam int CTRL_W = 8;
  localparam int BIT_PUD = 6;
  localparam int BIT_SE = 5;
  localparam int MODE_LO = 3;
  localparam int ISC_LO = 0;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'h7B;

  localparam gate_t GATE_ALL_ON = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Which domains keep running while asleep in a given mode.
  function automatic gate_t mode_gates(slp_mode_e m);
    gate_t g;
    case (m)
      MODE_IDLE:  g = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
      MODE_ADCQ:  g = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
      MODE_PDOWN: g = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
      default:    g = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
    endcase
    return g;
  endfunction

  // Oscillator settle time for the mode being left.
  function automatic int unsigned startup_len(slp_mode_e m, int unsigned d_idle,
                                              int unsigned d_adcq, int unsigned d_pdown,
                                              int unsigned d_stby);
    case (m)
      MODE_IDLE:  return d_idle;
      MODE_ADCQ:  return d_adcq;
      MODE_PDOWN: return d_pdown;
      default:    return d_stby;
    endcase
  endfunction

endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg
  import slp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              pud,
  output logic              se,
  output slp_mode_e         mode,
  output logic [1:0]        isc
);

  // A system reset clears the register and wins over a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (clr) begin
      ctrl_q <= '0;
    end else if (wr) begin
      ctrl_q <= wdata & CTRL_WMASK;
    end
  end

  assign pud  = ctrl_q[BIT_PUD];
  assign se   = ctrl_q[BIT_SE];
  assign mode = slp_mode_e'(ctrl_q[MODE_LO+1:MODE_LO]);
  assign isc  = ctrl_q[ISC_LO+1:ISC_LO];

endmodule

// File: rtl/slp_wake_seq.sv
module slp_wake_seq
  import slp_pkg::*;
#(
  parameter int unsigned D_IDLE   = 0,
  parameter int unsigned D_ADCQ   = 0,
  parameter int unsigned D_PDOWN  = 40,
  parameter int unsigned D_STBY   = 6,
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sleep_req,
  input  logic      sleep_en,
  input  slp_mode_e mode_sel,
  input  logic      irq_req,
  input  logic      rst_req,
  output seq_st_e   state,
  output slp_mode_e mode_lat,
  output logic      pulse_irq,
  output logic      pulse_rst,
  output logic      sleep_go,
  output logic      wake_go,
  output logic      hold_done
);

  localparam int unsigned MAXC = max_of(max_of(D_IDLE, D_ADCQ),
                                        max_of(max_of(D_PDOWN, D_STBY), HOLD_CYC));
  localparam int CW = $clog2(MAXC + 2);

  logic [CW-1:0] cnt_q;
  logic          cnt_zero;
  logic          path_rst_q;
  logic          path_rst_now;
  int unsigned   d_sel;

  always_comb d_sel = startup_len(mode_lat, D_IDLE, D_ADCQ, D_PDOWN, D_STBY);

  assign cnt_zero     = (cnt_q == '0);
  assign sleep_go     = (state == ST_RUN) && sleep_req && sleep_en;
  assign wake_go      = (state == ST_SLEEP) && (irq_req || rst_req);
  assign hold_done    = (state == ST_HOLD) && cnt_zero;
  assign path_rst_now = path_rst_q || rst_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      mode_lat   <= MODE_IDLE;
      cnt_q      <= '0;
      path_rst_q <= 1'b0;
      pulse_irq  <= 1'b0;
      pulse_rst  <= 1'b0;
    end else begin
      pulse_irq <= 1'b0;
      pulse_rst <= 1'b0;
      case (state)
        ST_RUN: begin
          if (sleep_go) begin
            state    <= ST_SLEEP;
            mode_lat <= mode_sel;
          end
        end
        ST_SLEEP: begin
          if (wake_go) begin
            path_rst_q <= rst_req;
            if (d_sel == 0) begin
              state <= ST_HOLD;
              cnt_q <= CW'(HOLD_CYC - 1);
            end else begin
              state <= ST_START;
              cnt_q <= CW'(d_sel - 1);
            end
          end
        end
        ST_START: begin
          path_rst_q <= path_rst_now;
          if (cnt_zero) begin
            state <= ST_HOLD;
            cnt_q <= CW'(HOLD_CYC - 1);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_HOLD: begin
          if (hold_done) begin
            state      <= ST_RUN;
            pulse_rst  <= path_rst_now;
            pulse_irq  <= !path_rst_now;
            path_rst_q <= 1'b0;
          end else begin
            path_rst_q <= path_rst_now;
            cnt_q      <= cnt_q - CW'(1);
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/slp_gate_dec.sv
module slp_gate_dec
  import slp_pkg::*;
(
  input  seq_st_e   state,
  input  slp_mode_e mode_lat,
  output gate_t     gates
);

  always_comb begin
    case (state)
      ST_SLEEP: gates = mode_gates(mode_lat);
      ST_START: begin
        gates     = mode_gates(mode_lat);
        gates.osc = 1'b1;
      end
      default:  gates = GATE_ALL_ON;
    endcase
  end

endmodule

// File: rtl/slp_pullup.sv
module slp_pullup #(
  parameter int NPINS = 8
) (
  input  logic             pud,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] dout,
  output logic [NPINS-1:0] pu
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pu[i] = !pud && !dir[i] && dout[i];
  end

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
  import slp_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int unsigned D_IDLE   = 0,
  parameter int unsigned D_ADCQ   = 0,
  parameter int unsigned D_PDOWN  = 40,
  parameter int unsigned D_STBY   = 6,
  parameter int unsigned HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_rst_req,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             sleep_exec,
  input  logic             irq_wake,
  input  logic [NPINS-1:0] pin_dir,
  input  logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pullup_en,
  output logic [1:0]       int_sense,
  output logic             core_halt,
  output logic             cpu_clk_run,
  output logic             io_clk_run,
  output logic             adc_clk_run,
  output logic             osc_run,
  output logic             resume_irq,
  output logic             resume_reset
);

  logic      pud;
  logic      se;
  slp_mode_e mode;
  seq_st_e   state;
  slp_mode_e mode_lat;
  gate_t     gates;

  // Named internal events for the checker.
  logic sleep_go;
  logic wake_go;
  logic hold_done;

  slp_ctrl_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sys_rst_req),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .ctrl_q (reg_rdata),
    .pud    (pud),
    .se     (se),
    .mode   (mode),
    .isc    (int_sense)
  );

  slp_wake_seq #(
    .D_IDLE   (D_IDLE),
    .D_ADCQ   (D_ADCQ),
    .D_PDOWN  (D_PDOWN),
    .D_STBY   (D_STBY),
    .HOLD_CYC (HOLD_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_exec),
    .sleep_en  (se),
    .mode_sel  (mode),
    .irq_req   (irq_wake),
    .rst_req   (sys_rst_req),
    .state     (state),
    .mode_lat  (mode_lat),
    .pulse_irq (resume_irq),
    .pulse_rst (resume_reset),
    .sleep_go  (sleep_go),
    .wake_go   (wake_go),
    .hold_done (hold_done)
  );

  slp_gate_dec u_gate (
    .state    (state),
    .mode_lat (mode_lat),
    .gates    (gates)
  );

  slp_pullup #(.NPINS(NPINS)) u_pu (
    .pud  (pud),
    .dir  (pin_dir),
    .dout (pin_out),
    .pu   (pullup_en)
  );

  assign core_halt   = (state != ST_RUN);
  assign cpu_clk_run = gates.cpu;
  assign io_clk_run  = gates.io;
  assign adc_clk_run = gates.adc;
  assign osc_run     = gates.osc;

endmodule

// File: rtl/slp_ctrl_chk.sv
module slp_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst_req,
  input logic       sleep_exec,
  input logic [7:0] reg_rdata,
  input logic       core_halt,
  input logic       cpu_clk_run,
  input logic       io_clk_run,
  input logic       adc_clk_run,
  input logic       osc_run,
  input logic       resume_irq,
  input logic       resume_reset,
  input logic       sleep_go,
  input logic       wake_go,
  input logic       hold_done
);

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b0) && (reg_rdata[2] == 1'b0));

  assert_enter_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_exec && reg_rdata[5]) |=> core_halt);

  assert_no_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_halt && sleep_exec && !reg_rdata[5]) |=> !core_halt);

  assert_go_from_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_go |-> !core_halt);

  assert_cpu_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_run |-> core_halt);

  assert_osc_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run |-> (!cpu_clk_run && !io_clk_run && !adc_clk_run));

  assert_wake_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_go |=> core_halt);

  assert_hold_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_done |=> (!core_halt && (resume_irq || resume_reset)));

  assert_resume_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_irq || resume_reset) |-> (!core_halt && $past(core_halt)));

  assert_hold_all_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_halt && cpu_clk_run) |-> (io_clk_run && adc_clk_run && osc_run));

  assert_rst_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> (reg_rdata == 8'h00));

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_irq && resume_reset));

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_irq || resume_reset) |=> !(resume_irq || resume_reset));

endmodule

bind slp_ctrl slp_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sys_rst_req  (sys_rst_req),
  .sleep_exec   (sleep_exec),
  .reg_rdata    (reg_rdata),
  .core_halt    (core_halt),
  .cpu_clk_run  (cpu_clk_run),
  .io_clk_run   (io_clk_run),
  .adc_clk_run  (adc_clk_run),
  .osc_run      (osc_run),
  .resume_irq   (resume_irq),
  .resume_reset (resume_reset),
  .sleep_go     (sleep_go),
  .wake_go      (wake_go),
  .hold_done    (hold_done)
);

// File: tb/slp_ctrl_bench.sv
module slp_ctrl_bench;
  localparam int NP    = 8;
  localparam int HOLDN = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sys_rst_req = 1'b0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = 8'h00;
  logic [7:0]    reg_rdata;
  logic          sleep_exec = 1'b0;
  logic          irq_wake = 1'b0;
  logic [NP-1:0] pin_dir = '0;
  logic [NP-1:0] pin_out = '0;
  logic [NP-1:0] pullup_en;
  logic [1:0]    int_sense;
  logic          core_halt, cpu_clk_run, io_clk_run, adc_clk_run, osc_run;
  logic          resume_irq, resume_reset;

  int checks = 0;
  int errors = 0;

  slp_ctrl #(.NPINS(NP)) u_slp_ctrl (
    .clk(clk), .rst_n(rst_n), .sys_rst_req(sys_rst_req), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_exec(sleep_exec),
    .irq_wake(irq_wake), .pin_dir(pin_dir), .pin_out(pin_out), .pullup_en(pullup_en),
    .int_sense(int_sense), .core_halt(core_halt), .cpu_clk_run(cpu_clk_run),
    .io_clk_run(io_clk_run), .adc_clk_run(adc_clk_run), .osc_run(osc_run),
    .resume_irq(resume_irq), .resume_reset(resume_reset)
  );

  wire [3:0] gates = {cpu_clk_run, io_clk_run, adc_clk_run, osc_run};

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected run pattern {cpu,io,adc,osc} while asleep.
  function automatic logic [3:0] exp_sleep_gates(logic [1:0] m);
    case (m)
      2'd0: return 4'b0111;
      2'd1: return 4'b0011;
      2'd2: return 4'b0000;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic int exp_delay(logic [1:0] m);
    if (m == 2'd2) return 40;
    if (m == 2'd3) return 6;
    return 0;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] w);
    return {1'b0, w[6:3], 1'b0, w[1:0]};
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_reg(logic [7:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic enter_sleep(logic [1:0] m);
    sleep_exec = 1'b1;
    tick();
    sleep_exec = 1'b0;
    chk("R2 halt after sleep_exec", core_halt, 1'b1);
    chk("R3 sleep gates", gates, exp_sleep_gates(m));
  endtask

  task automatic wake(logic by_irq, logic by_rst, logic [1:0] m, logic poke);
    int d;
    int n;
    logic rst_path;
    rst_path = by_rst;
    irq_wake = by_irq;
    sys_rst_req = by_rst;
    tick();
    irq_wake = 1'b0;
    sys_rst_req = 1'b0;
    d = exp_delay(m);
    n = 0;
    while (core_halt === 1'b1 && n < 400) begin
      if (n < d) chk("R6 start-up gates", gates, exp_sleep_gates(m) | 4'b0001);
      else       chk("R6 hold gates", gates, 4'hF);
      sleep_exec = poke && (n == 1);
      n++;
      tick();
    end
    sleep_exec = 1'b0;
    chk(poke ? "R10 halt length with sleep_exec poke" : "R5 halt length", n, d + HOLDN);
    chk("R5 resume_irq pulse", resume_irq, !rst_path);
    chk("R7 resume_reset pulse", resume_reset, rst_path);
    chk("R3 run gates", gates, 4'hF);
    if (rst_path) chk("R7 register cleared", reg_rdata, 8'h00);
    tick();
    chk("R11 pulse one cycle", {resume_irq, resume_reset}, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 reset value", reg_rdata, 8'h00);
    chk("R1 reset int_sense", int_sense, 2'b00);
    chk("R2 reset halt", core_halt, 1'b0);
    chk("R3 reset gates", gates, 4'hF);
    chk("R11 reset pulses", {resume_irq, resume_reset}, 2'b00);

    // R1 reserved bits and field positions
    write_reg(8'hFF);
    chk("R1 reserved read zero", reg_rdata, 8'h7B);
    chk("R1 int_sense field", int_sense, 2'b11);
    write_reg(8'h02);
    chk("R1 int_sense field 2", int_sense, 2'b10);

    // R9 pull-up disable on/off
    write_reg(8'h40);
    pin_dir = 8'h0F; pin_out = 8'hFF; #1;
    chk("R9 pud set", pullup_en, 8'h00);
    write_reg(8'h00);
    pin_dir = 8'h0F; pin_out = 8'hFF; #1;
    chk("R9 pud clear", pullup_en, 8'hF0);

    // R2 sleep_exec with enable clear
    sleep_exec = 1'b1; tick(); sleep_exec = 1'b0;
    chk("R2 no sleep when disabled", core_halt, 1'b0);
    chk("R2 gates stay on", gates, 4'hF);

    // R10 interrupt while running
    irq_wake = 1'b1; tick(); irq_wake = 1'b0;
    chk("R10 irq running halt", core_halt, 1'b0);
    chk("R10 irq running pulse", {resume_irq, resume_reset}, 2'b00);

    // R3/R5/R6 each mode with interrupt wake
    for (int m = 0; m < 4; m++) begin
      write_reg(8'h20 | 8'(m << 3));
      enter_sleep(2'(m));
      tick();
      chk("R3 gates held asleep", gates, exp_sleep_gates(2'(m)));
      wake(1'b1, 1'b0, 2'(m), 1'b0);
    end

    // R4 mode captured at entry
    write_reg(8'h30);
    enter_sleep(2'd2);
    write_reg(8'h20);
    chk("R4 gates keep latched mode", gates, 4'b0000);
    wake(1'b1, 1'b0, 2'd2, 1'b0);

    // R7 reset wake from standby, and priority over interrupt in idle
    write_reg(8'h38);
    enter_sleep(2'd3);
    wake(1'b0, 1'b1, 2'd3, 1'b0);
    write_reg(8'h20);
    enter_sleep(2'd0);
    wake(1'b1, 1'b1, 2'd0, 1'b0);

    // R10 sleep_exec during halt from power-down
    write_reg(8'h30);
    enter_sleep(2'd2);
    wake(1'b1, 1'b0, 2'd2, 1'b1);

    // R8 reset while running
    write_reg(8'h7B);
    sys_rst_req = 1'b1; tick(); sys_rst_req = 1'b0;
    chk("R8 register cleared", reg_rdata, 8'h00);
    chk("R8 halt low", core_halt, 1'b0);
    tick();
    chk("R8 no pulse", {resume_irq, resume_reset}, 2'b00);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] v;
      logic [1:0] m;
      logic [NP-1:0] dr, ou;
      int k;
      int kind;
      v = 8'($urandom) | 8'h20;
      m = v[4:3];
      write_reg(v);
      chk("R1 random readback", reg_rdata, exp_read(v));
      dr = NP'($urandom); ou = NP'($urandom);
      pin_dir = dr; pin_out = ou; #1;
      chk("R9 random pull-up", pullup_en, ~dr & ou & {NP{~v[6]}});
      enter_sleep(m);
      k = int'($urandom_range(0, 3));
      for (int j = 0; j < k; j++) begin
        tick();
        chk("R3 random asleep gates", gates, exp_sleep_gates(m));
      end
      kind = int'($urandom_range(0, 2));
      wake(kind != 1, kind != 0, m, 1'b0);
    end

    summary();
    $finish;
  end

endmodule